// File: doc/BRIEF.md
# Debug Command Decoder Sequencer

This block sits behind the serial shifter of a debug port. Each time the shifter has a complete byte, it raises a byte-valid strobe for one cycle. The sequencer reads the first byte as an opcode.

Opcodes that need operands then collect four more bytes, least significant first. The first two bytes form a 16-bit address. The next two form a 16-bit count or data word. Once all operands are in, the address and count/data registers are updated together. The sequencer then writes a 4-bit command code into its control register and raises a one-cycle jump request that carries the fixed firmware service vector 0x8010. The firmware reads the operands and the command code straight from these registers.

Register-map reads dispatch right away, with no operands. The no-operation opcode and every encoding outside the supported set are dropped silently. A synchronous abort input returns the sequencer to waiting for an opcode and throws away any operand bytes it has gathered so far.

Top module: `dbg_cmd_dispatch`

## Requirements
- R1: After reset, busy, jumpPulse, jumpVector, cmdCode, addrReg and cntReg are all zero.
- R2: Opcode 0x20, and any opcode other than 0x21 to 0x24, has no effect. busy stays low, no jump pulse is issued, and cmdCode, addrReg and cntReg keep their values.
- R3: Opcode 0x21 takes no operands. One cycle after it is accepted, cmdCode becomes 4'b0001 and the jump pulse is issued. addrReg and cntReg are unchanged.
- R4: Opcode 0x22 takes four operand bytes in the order address low, address high, count low, count high. Idle cycles may fall between these bytes. It then dispatches with cmdCode 4'b0010, with addrReg and cntReg holding the assembled values.
- R5: Opcode 0x23 uses the same operand order as R4 and dispatches with cmdCode 4'b0011.
- R6: Opcode 0x24 takes address low, address high, data low, data high. It dispatches with cmdCode 4'b0100 and accepts any address, including 0x0000 and 0xFFFF.
- R7: jumpPulse is high for exactly one cycle per dispatch. jumpVector reads 0x8010 in that cycle and 0x0000 at all other times.
- R8: busy is high from the cycle after an opcode is accepted up to the dispatch cycle. It is low in the cycle in which jumpPulse is high.
- R9: A byte strobed during the dispatch cycle (busy high with no operands outstanding) is ignored. It is not taken as a new opcode.
- R10: When abortReq is high at a clock edge, the sequencer returns to idle. This discards partial operands, so addrReg, cntReg and cmdCode keep their earlier values. Abort wins over a byte strobed in the same cycle, and an abort in the dispatch cycle suppresses the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| abortReq | input | 1 | Synchronous abort, returns to opcode wait |
| byteValid | input | 1 | One-cycle strobe marking byteIn valid |
| byteIn | input | 8 | Opcode or operand byte |
| addrReg | output | 16 | Operand address register |
| cntReg | output | 16 | Operand count/data register |
| cmdCode | output | 4 | Command code of the last dispatched command |
| jumpPulse | output | 1 | One-cycle jump request |
| jumpVector | output | 16 | Firmware vector, valid with jumpPulse |
| busy | output | 1 | Command in progress |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the abort and the final operand byte. The bench raises abortReq in the same cycle that the fourth operand byte is strobed. It then checks that busy is low, that no jump follows, and that the operand registers still hold the previous command's values.

The second pair is the dispatch cycle and a new byte. The bench strobes an opcode exactly in the cycle where busy is high with no operands outstanding, and expects busy to stay low after the jump. It also places an abort in the dispatch cycle and expects jumpPulse to stay low and cmdCode to be unchanged.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int BYTE_W     = 8;
  localparam int OPERAND_W  = 16;
  localparam int CODE_W     = 4;
  localparam int HALF_BYTES = OPERAND_W / BYTE_W;
  localparam int OPND_BYTES = 2 * HALF_BYTES;
  localparam int IDX_W      = $clog2(OPND_BYTES);

  typedef struct packed {
    logic              captureEn;
    logic [IDX_W-1:0]  captureIdx;
    logic              commit;
    logic              writeCode;
    logic [CODE_W-1:0] code;
    logic              fire;
  } seqStrobes_t;

  typedef struct packed {
    logic              known;
    logic              needsOperands;
    logic [CODE_W-1:0] code;
  } opDecode_t;

  function automatic opDecode_t decodeOpcode(input logic [BYTE_W-1:0] op);
    opDecode_t d;
    d = '0;
    case (op)
      8'h21: begin d.known = 1'b1; d.needsOperands = 1'b0; d.code = 4'h1; end
      8'h22: begin d.known = 1'b1; d.needsOperands = 1'b1; d.code = 4'h2; end
      8'h23: begin d.known = 1'b1; d.needsOperands = 1'b1; d.code = 4'h3; end
      8'h24: begin d.known = 1'b1; d.needsOperands = 1'b1; d.code = 4'h4; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortReq,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output seqStrobes_t       strobes,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OPND_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OPERAND, ST_DISPATCH} seqState_t;

  seqState_t         state;
  logic [IDX_W-1:0]  opIdx;
  logic [CODE_W-1:0] pendCode;
  logic              pendOps;
  opDecode_t         dec;

  assign dec  = decodeOpcode(byteIn);
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobes      = '0;
    strobes.code = pendCode;
    if (!abortReq) begin
      case (state)
        ST_OPERAND: begin
          strobes.captureEn  = byteValid;
          strobes.captureIdx = opIdx;
        end
        ST_DISPATCH: begin
          strobes.writeCode = 1'b1;
          strobes.fire      = 1'b1;
          strobes.commit    = pendOps;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opIdx    <= '0;
      pendCode <= '0;
      pendOps  <= 1'b0;
    end else if (abortReq) begin
      state <= ST_IDLE;
      opIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (byteValid && dec.known) begin
            pendCode <= dec.code;
            pendOps  <= dec.needsOperands;
            opIdx    <= '0;
            state    <= dec.needsOperands ? ST_OPERAND : ST_DISPATCH;
          end
        end
        ST_OPERAND: begin
          if (byteValid) begin
            if (opIdx == LAST_IDX) state <= ST_DISPATCH;
            else                   opIdx <= opIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (state == ST_IDLE));

  assert_unlisted_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && byteValid && !dec.known && !abortReq) |=> (state == ST_IDLE));

  assert_dispatch_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISPATCH) |=> (state == ST_IDLE));

  assert_operand_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPERAND && byteValid && !abortReq && opIdx == LAST_IDX)
      |=> (state == ST_DISPATCH));
endmodule

// File: rtl/dbg_seq_datapath.sv
module dbg_seq_datapath
  import dbg_cmd_pkg::*;
#(
  parameter logic [OPERAND_W-1:0] VECTOR = 16'h8010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BYTE_W-1:0]    byteIn,
  input  seqStrobes_t          strobes,
  output logic [OPERAND_W-1:0] addrReg,
  output logic [OPERAND_W-1:0] cntReg,
  output logic [CODE_W-1:0]    cmdCode,
  output logic                 jumpPulse,
  output logic [OPERAND_W-1:0] jumpVector
);
  logic [BYTE_W-1:0]    stage [OPND_BYTES];
  logic [OPERAND_W-1:0] stageAddr;
  logic [OPERAND_W-1:0] stageCnt;

  for (genvar g = 0; g < OPND_BYTES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN)
        stage[g] <= '0;
      else if (strobes.captureEn && strobes.captureIdx == IDX_W'(g))
        stage[g] <= byteIn;
    end
  end

  for (genvar h = 0; h < HALF_BYTES; h++) begin : gAssemble
    assign stageAddr[h*BYTE_W +: BYTE_W] = stage[h];
    assign stageCnt[h*BYTE_W +: BYTE_W]  = stage[HALF_BYTES + h];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      cntReg     <= '0;
      cmdCode    <= '0;
      jumpPulse  <= 1'b0;
      jumpVector <= '0;
    end else begin
      if (strobes.commit) begin
        addrReg <= stageAddr;
        cntReg  <= stageCnt;
      end
      if (strobes.writeCode) cmdCode <= strobes.code;
      jumpPulse  <= strobes.fire;
      jumpVector <= strobes.fire ? VECTOR : '0;
    end
  end

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    jumpPulse |=> !jumpPulse);

  assert_vector_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    jumpPulse |-> (jumpVector == VECTOR));

  assert_vector_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !jumpPulse |-> (jumpVector == '0));

  assert_operands_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(addrReg) && $stable(cntReg)));

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.writeCode |=> $stable(cmdCode));
endmodule

// File: rtl/dbg_cmd_dispatch.sv
module dbg_cmd_dispatch
  import dbg_cmd_pkg::*;
#(
  parameter logic [OPERAND_W-1:0] VECTOR = 16'h8010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 abortReq,
  input  logic                 byteValid,
  input  logic [BYTE_W-1:0]    byteIn,
  output logic [OPERAND_W-1:0] addrReg,
  output logic [OPERAND_W-1:0] cntReg,
  output logic [CODE_W-1:0]    cmdCode,
  output logic                 jumpPulse,
  output logic [OPERAND_W-1:0] jumpVector,
  output logic                 busy
);
  seqStrobes_t strobes;

  dbg_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .abortReq  (abortReq),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobes   (strobes),
    .busy      (busy)
  );

  dbg_seq_datapath #(.VECTOR(VECTOR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .byteIn     (byteIn),
    .strobes    (strobes),
    .addrReg    (addrReg),
    .cntReg     (cntReg),
    .cmdCode    (cmdCode),
    .jumpPulse  (jumpPulse),
    .jumpVector (jumpVector)
  );

  assert_idle_at_jump_R8: assert property (@(posedge clk) disable iff (!rstN)
    jumpPulse |-> !busy);
endmodule

// File: tb/dbg_cmd_dispatch_bench.sv
`timescale 1ns/1ps
module dbg_cmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        abortReq = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic [15:0] addrReg, cntReg, jumpVector;
  logic [3:0]  cmdCode;
  logic        jumpPulse, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] expAddr = '0;
  logic [15:0] expCnt  = '0;
  logic [3:0]  expCode = '0;

  always #4 clk = ~clk;

  dbg_cmd_dispatch u_dbg_cmd_dispatch (
    .clk(clk), .rstN(rstN), .abortReq(abortReq), .byteValid(byteValid),
    .byteIn(byteIn), .addrReg(addrReg), .cntReg(cntReg), .cmdCode(cmdCode),
    .jumpPulse(jumpPulse), .jumpVector(jumpVector), .busy(busy)
  );

  // entry: opcode[44:37], needsOps[36], addr[35:20], cnt[19:4], code[3:0]
  localparam int NVEC = 9;
  localparam logic [44:0] VECS [NVEC] = '{
    {8'h20, 1'b0, 16'h0000, 16'h0000, 4'h0},
    {8'h22, 1'b1, 16'h1234, 16'h0005, 4'h2},
    {8'h21, 1'b0, 16'h0000, 16'h0000, 4'h1},
    {8'h23, 1'b1, 16'h00FF, 16'h0003, 4'h3},
    {8'h7F, 1'b0, 16'h0000, 16'h0000, 4'h0},
    {8'h24, 1'b1, 16'hFFFF, 16'hA55A, 4'h4},
    {8'h25, 1'b0, 16'h0000, 16'h0000, 4'h0},
    {8'h24, 1'b1, 16'h0000, 16'h0001, 4'h4},
    {8'h00, 1'b0, 16'h0000, 16'h0000, 4'h0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    tick();
    byteValid = 1'b0;
  endtask

  task automatic sendOperands(input logic [15:0] a, input logic [15:0] c, input bit gaps);
    sendByte(a[7:0]);
    if (gaps) tick();
    sendByte(a[15:8]);
    if (gaps) begin tick(); tick(); end
    sendByte(c[7:0]);
    sendByte(c[15:8]);
  endtask

  function automatic string reqOf(input logic [3:0] code);
    case (code)
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic expectDispatch(input string req);
    chk({req, " busy before jump (R8)"}, busy, 1);
    chk({req, " no early pulse (R8)"}, jumpPulse, 0);
    tick();
    chk({req, " jump pulse (R7)"}, jumpPulse, 1);
    chk({req, " vector R7"}, jumpVector, 16'h8010);
    chk({req, " busy low at jump R8"}, busy, 0);
    chk({req, " cmdCode"}, cmdCode, expCode);
    chk({req, " addrReg"}, addrReg, expAddr);
    chk({req, " cntReg"}, cntReg, expCnt);
    tick();
    chk("R7 pulse one cycle", jumpPulse, 0);
    chk("R7 vector quiet", jumpVector, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 busy", busy, 0);
    chk("R1 jumpPulse", jumpPulse, 0);
    chk("R1 jumpVector", jumpVector, 0);
    chk("R1 cmdCode", cmdCode, 0);
    chk("R1 addrReg", addrReg, 0);
    chk("R1 cntReg", cntReg, 0);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      logic [44:0] v;
      v = VECS[i];
      sendByte(v[44:37]);
      if (v[36]) begin
        chk("R8 busy during operands", busy, 1);
        sendOperands(v[35:20], v[19:4], (i % 2) == 1);
        expAddr = v[35:20];
        expCnt  = v[19:4];
      end
      if (v[3:0] != 4'h0) begin
        expCode = v[3:0];
        expectDispatch(reqOf(v[3:0]));
      end else begin
        chk("R2 no busy", busy, 0);
        tick();
        chk("R2 no jump", jumpPulse, 0);
        chk("R2 cmdCode kept", cmdCode, expCode);
        chk("R2 addrReg kept", addrReg, expAddr);
        chk("R2 cntReg kept", cntReg, expCnt);
      end
    end

    // R9: byte strobed in dispatch cycle is ignored
    sendByte(8'h21);
    byteValid = 1'b1; byteIn = 8'h22;
    tick();
    byteValid = 1'b0;
    expCode = 4'h1;
    chk("R9 jump still issued", jumpPulse, 1);
    chk("R9 byte ignored, busy low", busy, 0);
    tick();
    chk("R9 still idle", busy, 0);

    // R10: abort mid-operand discards partial operands
    sendByte(8'h22);
    sendByte(8'hAA);
    sendByte(8'hBB);
    abortReq = 1'b1; tick(); abortReq = 1'b0;
    chk("R10 idle after abort", busy, 0);
    tick();
    chk("R10 no jump after abort", jumpPulse, 0);
    chk("R10 addrReg kept", addrReg, expAddr);
    sendByte(8'h24);
    sendOperands(16'h4321, 16'h8765, 1'b0);
    expAddr = 16'h4321; expCnt = 16'h8765; expCode = 4'h4;
    expectDispatch("R10 fresh after abort R6");

    // R10: abort in same cycle as final operand byte
    sendByte(8'h23);
    sendByte(8'h01); sendByte(8'h02); sendByte(8'h03);
    abortReq = 1'b1; byteValid = 1'b1; byteIn = 8'h04;
    tick();
    abortReq = 1'b0; byteValid = 1'b0;
    chk("R10 abort beats byte, busy", busy, 0);
    tick();
    chk("R10 abort beats byte, no jump", jumpPulse, 0);
    chk("R10 abort beats byte, addrReg", addrReg, expAddr);
    chk("R10 abort beats byte, cntReg", cntReg, expCnt);

    // R10: abort in dispatch cycle suppresses jump
    sendByte(8'h21);
    abortReq = 1'b1; tick(); abortReq = 1'b0;
    chk("R10 dispatch abort no jump", jumpPulse, 0);
    chk("R10 dispatch abort cmdCode", cmdCode, expCode);
    chk("R10 dispatch abort busy", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule